// File: doc/BRIEF.md
# Duty-Cycled Multi-Channel Sampling Scheduler

This block paces the conversions of a low-power capacitive sensor interface. One acceleration converter is shared, through a single front end, by up to four proof-mass channels. A second converter reads temperature. The scheduler counts the 2 MHz system clock to form a frame tick for acceleration and a separate tick for temperature. It selects which proof mass the front end reads and sends one-clock start pulses to the two converter sequencers. Each converter, with its reference, is powered only from a programmable warm-up lead before its start until that conversion reports done.

Within an acceleration frame, the active channels are converted one at a time in ascending index order. The channel count (one, two or four) is captured when a frame begins, so a new setting takes effect at the next frame. The temperature path runs on its own divider and warm-up. At the default 100 S/s with a 12-clock lead and a 48-clock conversion, it is powered for 60 clocks out of every 20000. Each proof-mass channel defaults to 1 kS/s (divider 2000).

Top module: `duty_sample_sched`

## Requirements
- R1: While `rst` is high and after its release, before any tick is accepted, `ch_sel` is 0 and `accel_start`, `temp_start`, `accel_pwr`, `temp_pwr` and `busy` are low.
- R2: When a frame fits in its period, start pulses for channel 0 come exactly `accel_div` clocks apart, and temperature start pulses come exactly `temp_div` clocks apart.
- R3: `mode_sel` 0 converts channel 0 only; 1 converts channels 0 and 1; 2 or 3 converts channels 0 to 3. Channels go in ascending order, and `ch_sel` shows the channel being converted while its power is on.
- R4: Only one channel is converted at a time. Power for the next channel rises on the clock after the previous done is sampled, so starts within a frame are warm+L+1 clocks apart for a conversion that takes L clocks from start to done.
- R5: Each start pulse is high for exactly one clock and comes exactly warm clocks after its power enable rises. A warm-up setting of 0 behaves as 1.
- R6: A power enable falls on the clock edge at which the matching done is sampled high. It is therefore high for warm+L clocks per conversion.
- R7: The temperature path is independent of the acceleration path. With `temp_div`=20000 and `temp_warm`=12, a 48-clock conversion gives a 60-clock power window every 20000 clocks.
- R8: A change of `mode_sel` during a frame does not alter that frame. The new channel count applies from the next accepted frame tick.
- R9: A frame tick that arrives while the previous frame is still converting is dropped. The next frame starts at the first tick after the previous frame has finished, so the channel-0 period becomes a whole multiple of `accel_div`.
- R10: A done input that is high while its converter is not converting has no effect on power, start or channel.
- R11: `busy` is high whenever either power enable is high, and low when both paths are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Channel count: 0 one, 1 two, 2/3 four |
| accel_div | input | DIV_W | Acceleration frame period in clocks |
| temp_div | input | DIV_W | Temperature sample period in clocks |
| accel_warm | input | WARM_W | Acceleration power lead before start |
| temp_warm | input | WARM_W | Temperature power lead before start |
| accel_done | input | 1 | Acceleration conversion finished |
| temp_done | input | 1 | Temperature conversion finished |
| ch_sel | output | 2 | Proof-mass channel routed to the front end |
| accel_start | output | 1 | One-clock acceleration conversion request |
| temp_start | output | 1 | One-clock temperature conversion request |
| accel_pwr | output | 1 | Acceleration converter and reference enable |
| temp_pwr | output | 1 | Temperature converter and reference enable |
| busy | output | 1 | Either path has a conversion pending |

## Verification
Some rules are checked by the assertions on every cycle. Start pulses last one clock and only occur with power already on. Power drops only where a done was sampled. The channel select stays still while power is on, and `busy` covers both enables. Other behaviour needs the bench scenarios with their timed converter responses. These cover the exact divider periods, the ascending channel order and per-frame channel count for each mode, and the warm-up and on-window lengths. The bench scenarios also show that a mode change is deferred to the next frame, that overrun ticks are dropped, and that a stray done has no effect.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int MAX_CH = 4;
    localparam int CH_W   = $clog2(MAX_CH);

    typedef enum logic [1:0] {
        MODE_ONE      = 2'd0,
        MODE_TWO      = 2'd1,
        MODE_FOUR     = 2'd2,
        MODE_FOUR_ALT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_WARM,
        ENG_CONV,
        ENG_NEXT
    } eng_state_e;

    typedef struct packed {
        eng_state_e          st;
        logic [CH_W-1:0]     ch;
        logic [CH_W-1:0]     last;
    } eng_pos_t;

    // Highest channel index served in a frame for a given mode setting.
    function automatic logic [CH_W-1:0] last_index(input logic [1:0] m);
        case (mode_e'(m))
            MODE_ONE: last_index = CH_W'(0);
            MODE_TWO: last_index = CH_W'(1);
            default:  last_index = CH_W'(MAX_CH - 1);
        endcase
    endfunction

endpackage

// File: rtl/rate_timer.sv
module rate_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // A divider of zero behaves as one: a tick every clock.
    assign lim = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/conv_engine.sv
module conv_engine
    import sched_pkg::*;
#(
    parameter int WARM_W = 8,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [WARM_W-1:0] warm,
    input  logic [CW-1:0]     last_ch,
    input  logic              done,
    output logic [CW-1:0]     ch,
    output logic              start,
    output logic              pwr,
    output logic              active
);

    eng_state_e        st;
    logic [WARM_W-1:0] wcnt;
    logic [WARM_W-1:0] warm_eff;
    logic [CW-1:0]     last_q;

    assign warm_eff = (warm == '0) ? WARM_W'(1) : warm;
    assign active   = (st != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ENG_IDLE;
            wcnt   <= '0;
            ch     <= '0;
            last_q <= '0;
            start  <= 1'b0;
            pwr    <= 1'b0;
        end else begin
            start <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    // Ticks seen in any other state are dropped.
                    if (tick) begin
                        last_q <= last_ch;
                        ch     <= '0;
                        pwr    <= 1'b1;
                        wcnt   <= warm_eff;
                        st     <= ENG_WARM;
                    end
                end
                ENG_WARM: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == WARM_W'(1)) begin
                        start <= 1'b1;
                        st    <= ENG_CONV;
                    end
                end
                ENG_CONV: begin
                    if (done) begin
                        pwr <= 1'b0;
                        st  <= (ch == last_q) ? ENG_IDLE : ENG_NEXT;
                    end
                end
                ENG_NEXT: begin
                    ch   <= ch + 1'b1;
                    pwr  <= 1'b1;
                    wcnt <= warm_eff;
                    st   <= ENG_WARM;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/duty_sample_sched.sv
module duty_sample_sched
    import sched_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int WARM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [DIV_W-1:0]  accel_div,
    input  logic [DIV_W-1:0]  temp_div,
    input  logic [WARM_W-1:0] accel_warm,
    input  logic [WARM_W-1:0] temp_warm,
    input  logic              accel_done,
    input  logic              temp_done,
    output logic [CH_W-1:0]   ch_sel,
    output logic              accel_start,
    output logic              temp_start,
    output logic              accel_pwr,
    output logic              temp_pwr,
    output logic              busy
);

    localparam int N_PATH = 2;
    localparam int P_ACC  = 0;
    localparam int P_TMP  = 1;

    logic [DIV_W-1:0]  div_arr [N_PATH];
    logic [N_PATH-1:0] ticks;
    logic              a_active;
    logic              t_active;
    logic [0:0]        t_ch_unused;

    assign div_arr[P_ACC] = accel_div;
    assign div_arr[P_TMP] = temp_div;

    for (genvar p = 0; p < N_PATH; p++) begin : g_timer
        rate_timer #(.DIV_W(DIV_W)) u_timer (
            .clk  (clk),
            .rst  (rst),
            .div  (div_arr[p]),
            .tick (ticks[p])
        );
    end

    conv_engine #(.WARM_W(WARM_W), .CW(CH_W)) u_accel (
        .clk     (clk),
        .rst     (rst),
        .tick    (ticks[P_ACC]),
        .warm    (accel_warm),
        .last_ch (last_index(mode_sel)),
        .done    (accel_done),
        .ch      (ch_sel),
        .start   (accel_start),
        .pwr     (accel_pwr),
        .active  (a_active)
    );

    conv_engine #(.WARM_W(WARM_W), .CW(1)) u_temp (
        .clk     (clk),
        .rst     (rst),
        .tick    (ticks[P_TMP]),
        .warm    (temp_warm),
        .last_ch (1'b0),
        .done    (temp_done),
        .ch      (t_ch_unused),
        .start   (temp_start),
        .pwr     (temp_pwr),
        .active  (t_active)
    );

    assign busy = a_active | t_active;

endmodule

// File: rtl/sched_chk.sv
module sched_chk
    import sched_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            accel_done,
    input logic            temp_done,
    input logic [CH_W-1:0] ch_sel,
    input logic            accel_start,
    input logic            temp_start,
    input logic            accel_pwr,
    input logic            temp_pwr,
    input logic            busy
);

    // R5
    accel_start_width_chk: assert property (@(posedge clk) disable iff (rst)
        accel_start |=> !accel_start);
    // R5
    temp_start_width_chk: assert property (@(posedge clk) disable iff (rst)
        temp_start |=> !temp_start);
    // R5
    accel_warm_lead_chk: assert property (@(posedge clk) disable iff (rst)
        accel_start |-> (accel_pwr && $past(accel_pwr)));
    // R5
    temp_warm_lead_chk: assert property (@(posedge clk) disable iff (rst)
        temp_start |-> (temp_pwr && $past(temp_pwr)));
    // R6
    accel_pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(accel_pwr) |-> $past(accel_done));
    // R6
    temp_pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(temp_pwr) |-> $past(temp_done));
    // R3
    ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (accel_pwr && $past(accel_pwr)) |-> $stable(ch_sel));
    // R11
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (accel_pwr || temp_pwr) |-> busy);

endmodule

bind duty_sample_sched sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .accel_done  (accel_done),
    .temp_done   (temp_done),
    .ch_sel      (ch_sel),
    .accel_start (accel_start),
    .temp_start  (temp_start),
    .accel_pwr   (accel_pwr),
    .temp_pwr    (temp_pwr),
    .busy        (busy)
);

// File: tb/sim_duty_sample_sched.sv
module sim_duty_sample_sched;

    localparam int CONV_L   = 48;
    localparam int WD_LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode;
    logic [15:0] adiv, tdiv;
    logic [7:0]  aw, tw;
    logic        a_done_m, t_done_m, inj_a;
    logic        accel_done, temp_done;
    logic [1:0]  ch_sel;
    logic        accel_start, temp_start, accel_pwr, temp_pwr, busy;

    assign accel_done = a_done_m | inj_a;
    assign temp_done  = t_done_m;

    always #4 clk = ~clk;

    duty_sample_sched u0 (
        .clk(clk), .rst(rst), .mode_sel(mode), .accel_div(adiv), .temp_div(tdiv),
        .accel_warm(aw), .temp_warm(tw), .accel_done(accel_done), .temp_done(temp_done),
        .ch_sel(ch_sel), .accel_start(accel_start), .temp_start(temp_start),
        .accel_pwr(accel_pwr), .temp_pwr(temp_pwr), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [15:0] ad;
        logic [7:0]  aw;
        logic [15:0] td;
        logic [7:0]  tw;
        logic [2:0]  nch;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{m: 2'd0, ad: 16'd150, aw: 8'd1, td: 16'd700,  tw: 8'd3,  nch: 3'd1},
        '{m: 2'd1, ad: 16'd250, aw: 8'd2, td: 16'd900,  tw: 8'd0,  nch: 3'd2},
        '{m: 2'd2, ad: 16'd300, aw: 8'd5, td: 16'd600,  tw: 8'd12, nch: 3'd4},
        '{m: 2'd3, ad: 16'd400, aw: 8'd0, td: 16'd1000, tw: 8'd7,  nch: 3'd4}
    };

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // converter response models: done sampled CONV_L edges after the start edge
    int acnt = 0, tcnt = 0;
    always @(negedge clk) begin
        if (rst) begin acnt = 0; a_done_m = 0; end
        else if (accel_start) begin acnt = CONV_L - 1; a_done_m = 0; end
        else if (acnt > 0) begin acnt--; a_done_m = (acnt == 0); end
        else a_done_m = 0;
    end
    always @(negedge clk) begin
        if (rst) begin tcnt = 0; t_done_m = 0; end
        else if (temp_start) begin tcnt = CONV_L - 1; t_done_m = 0; end
        else if (tcnt > 0) begin tcnt--; t_done_m = (tcnt == 0); end
        else t_done_m = 0;
    end

    // monitor state
    int cyc, a0_t, n_a0, prev_ch, aprev_t, cur_fn, nf;
    int a_per_err, a_gap_err, seq_err, warm_err, pulse_err, a_on, a_on_err, n_a_win;
    int t_prev, n_t, t_per_err, t_on, t_on_err, n_t_win, busy_err;
    int exp_a_per, exp_t_per, exp_aw, exp_tw, exp_a_on, exp_t_on, exp_gap;
    int frames [32];
    bit have_a0, a_sp, t_sp;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (accel_start) begin
                if (a_on != exp_aw) warm_err++;
                if (a_sp) pulse_err++;
                if (ch_sel == 2'd0) begin
                    if (have_a0) begin
                        if (cyc - a0_t != exp_a_per) a_per_err++;
                        if (nf < 32) begin frames[nf] = cur_fn; nf++; end
                    end
                    have_a0 = 1; a0_t = cyc; n_a0++; cur_fn = 1;
                end else begin
                    if (int'(ch_sel) != prev_ch + 1) seq_err++;
                    if (cyc - aprev_t != exp_gap) a_gap_err++;
                    cur_fn++;
                end
                prev_ch = int'(ch_sel); aprev_t = cyc;
            end
            a_sp = accel_start;
            if (temp_start) begin
                if (t_on != exp_tw) warm_err++;
                if (t_sp) pulse_err++;
                if (n_t > 0 && cyc - t_prev != exp_t_per) t_per_err++;
                t_prev = cyc; n_t++;
            end
            t_sp = temp_start;
            if (accel_pwr) a_on++;
            else if (a_on != 0) begin if (a_on != exp_a_on) a_on_err++; n_a_win++; a_on = 0; end
            if (temp_pwr) t_on++;
            else if (t_on != 0) begin if (t_on != exp_t_on) t_on_err++; n_t_win++; t_on = 0; end
            if ((accel_pwr || temp_pwr) && !busy) busy_err++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] m, input int ad, input int aw_, input int td, input int tw_);
        @(negedge clk);
        rst = 1; inj_a = 0;
        mode = m; adiv = 16'(ad); aw = 8'(aw_); tdiv = 16'(td); tw = 8'(tw_);
        cyc = 0; a0_t = 0; n_a0 = 0; prev_ch = 0; aprev_t = 0; cur_fn = 0; nf = 0;
        a_per_err = 0; a_gap_err = 0; seq_err = 0; warm_err = 0; pulse_err = 0;
        a_on = 0; a_on_err = 0; n_a_win = 0; t_prev = 0; n_t = 0; t_per_err = 0;
        t_on = 0; t_on_err = 0; n_t_win = 0; busy_err = 0; have_a0 = 0; a_sp = 0; t_sp = 0;
        exp_aw = (aw_ == 0) ? 1 : aw_;
        exp_tw = (tw_ == 0) ? 1 : tw_;
        exp_a_on = exp_aw + CONV_L; exp_t_on = exp_tw + CONV_L;
        exp_gap = exp_aw + CONV_L + 1;
        exp_a_per = ad; exp_t_per = td;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic common_checks(input int nch, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < nf; i++) if (frames[i] != nch) bad++;
        check(a_per_err == 0 && n_a0 >= 2, {"R2 accel period ", tag}, a_per_err, 0);
        check(t_per_err == 0 && n_t >= 2, {"R2 temp period ", tag}, t_per_err, 0);
        check(bad == 0 && nf >= 1, {"R3 channels per frame ", tag}, bad, 0);
        check(seq_err == 0, {"R3 ascending order ", tag}, seq_err, 0);
        check(a_gap_err == 0, {"R4 intra-frame spacing ", tag}, a_gap_err, 0);
        check(warm_err == 0 && pulse_err == 0, {"R5 warm lead and pulse ", tag}, warm_err + pulse_err, 0);
        check(a_on_err == 0 && n_a_win >= 1, {"R6 accel on-window ", tag}, a_on_err, 0);
        check(t_on_err == 0 && n_t_win >= 1, {"R6 temp on-window ", tag}, t_on_err, 0);
        check(busy_err == 0, {"R11 busy cover ", tag}, busy_err, 0);
    endtask

    initial begin
        #(8 * WD_LIMIT);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mode = 0; adiv = 16'd2000; tdiv = 16'd20000; aw = 8'd4; tw = 8'd12; inj_a = 0;
        // R1 reset state
        repeat (4) @(negedge clk);
        check(ch_sel == 0 && !accel_start && !temp_start && !accel_pwr && !temp_pwr && !busy,
              "R1 outputs in reset", {ch_sel, accel_start, temp_start, accel_pwr, temp_pwr, busy}, 0);

        // table of configurations
        for (int v = 0; v < 4; v++) begin
            setup(VECS[v].m, int'(VECS[v].ad), int'(VECS[v].aw), int'(VECS[v].td), int'(VECS[v].tw));
            if (v == 0) begin
                repeat (2) @(negedge clk);
                check(!busy && !accel_pwr && !temp_pwr, "R1 idle after release", busy, 0);
            end
            repeat (3200) @(negedge clk);
            common_checks(int'(VECS[v].nch), $sformatf("vec%0d", v));
        end

        // R7 default rates: 60-clock temperature window every 20000 clocks
        setup(2'd2, 2000, 4, 20000, 12);
        repeat (41000) @(negedge clk);
        check(t_per_err == 0 && n_t >= 2, "R7 temp period 20000", t_per_err, 0);
        check(t_on_err == 0 && n_t_win >= 2 && exp_t_on == 60, "R7 temp window 60", t_on_err, 0);
        check(a_per_err == 0 && n_a0 >= 10, "R7 accel independent at 2000", a_per_err, 0);

        // R8 mode change inside a frame
        setup(2'd1, 400, 4, 5000, 4);
        begin
            int seen;
            seen = 0;
            while (seen < 2) begin
                @(negedge clk);
                if (accel_start && ch_sel == 2'd0) seen++;
            end
        end
        mode = 2'd2;
        repeat (1300) @(negedge clk);
        check(nf >= 3 && frames[1] == 2, "R8 frame in progress keeps old count", frames[1], 2);
        check(nf >= 3 && frames[2] == 4, "R8 next frame uses new count", frames[2], 4);

        // R9 overrun: a 4-channel frame lasts longer than two periods of 100
        setup(2'd2, 100, 4, 5000, 4);
        exp_a_per = 300;
        repeat (1500) @(negedge clk);
        check(a_per_err == 0 && n_a0 >= 3, "R9 dropped ticks give period 300", a_per_err, 0);

        // R10 stray done during warm-up and while idle
        setup(2'd0, 300, 20, 5000, 4);
        while (!accel_pwr) @(negedge clk);
        inj_a = 1; @(negedge clk); inj_a = 0;
        while (accel_pwr) @(negedge clk);
        repeat (5) @(negedge clk);
        inj_a = 1; @(negedge clk); inj_a = 0;
        repeat (2) @(negedge clk);
        check(!accel_pwr && !accel_start, "R10 idle done ignored", accel_pwr, 0);
        repeat (1000) @(negedge clk);
        check(a_on_err == 0 && n_a_win >= 2, "R10 warm-up done ignored", a_on_err, 0);
        check(a_per_err == 0 && n_a0 >= 3, "R10 period unaffected", a_per_err, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule